// File: doc/BRIEF.md
# Serial Flash Page-Program Sequencer

This engine writes a run of bytes into a serial NOR flash through an SPI command controller that sits beside it. Software or another engine supplies a start address, a byte count and a page size given as a power-of-two shift, then pulses `start`. The sequencer splits the run at flash page boundaries. For each page it runs the same round: it flushes the controller FIFOs, sends a lone write-enable instruction, and opens a page-program frame carrying a 3-byte address. It then streams the page's bytes from a valid/ready input, closes the frame, and polls the flash status register until the busy bit clears.

The controller is driven through a small command port. Each command is one of five kinds (flush, open frame, write byte, read byte, close frame) and is held until the controller accepts it. Status bytes come back on a one-byte response port. A fixed poll watchdog bounds the busy wait. When it expires, the frame is closed and an error pulse ends the operation.

Top module: `flash_prog_seq`

## Requirements
- R1: Open commands (kind code 1) carry one of three opcodes. Write-enable 0x06 has address length 0 and the read flag at 0. Page-program 0x02 has address length 3, the read flag at 0, and `cmdAddr` equal to the flash address of the first byte of the page. Read-status 0x05 has address length 0 and the read flag at 1.
- R2: Each page round begins with this command order: flush (code 0), open 0x06, close (code 4), open 0x02. Every command is held with stable fields until `cmdReady` accepts it.
- R3: The page size is 2^`pageShift`. The first page end is the smallest multiple of the page size strictly above the start address. Each later page end is the previous one plus the page size.
- R4: Each accepted input byte becomes one write-byte command (code 2) with the same data, in stream order. The flash address advances by one per byte. The program frame closes after the byte that reaches the page end or uses up the count, and no byte beyond the count is taken.
- R5: After each program frame the engine sends flush, open 0x05, then read-byte commands (code 3), one at a time after each response. Polling stops at the first response whose bit 0 is 0, whatever the other bits hold, and a close follows.
- R6: After the busy wait, `done` pulses for one cycle if the count is used up. Otherwise the next page round starts with a flush.
- R7: A start with a byte count of zero raises `done` in the cycle right after the start edge and issues no command.
- R8: When POLL_LIMIT status reads in one poll all return busy, the engine closes the frame, pulses `abortErr` for one cycle without `done`, and issues nothing more. POLL_LIMIT-1 busy reads followed by a ready read completes normally.
- R9: A `pageShift` below 4 is treated as 4, and one above 12 is treated as 12, so the page size is always between 16 and 4096 bytes.
- R10: `active` is high from an accepted start until the cycle `done` or `abortErr` rises. A start while active is ignored.
- R11: After reset, `active`, `done`, `abortErr`, `cmdValid` and `inReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| startAddr | input | ADDR_W | First flash address to write |
| byteCount | input | CNT_W | Number of bytes to write |
| pageShift | input | 4 | Page size as a power of two, clamped to 4..12 |
| active | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| abortErr | output | 1 | One-cycle pulse on poll watchdog abort |
| inData | input | 8 | Byte stream data |
| inValid | input | 1 | Byte stream valid |
| inReady | output | 1 | Byte stream ready |
| cmdValid | output | 1 | Command valid |
| cmdReady | input | 1 | Controller accepts the command |
| cmdKind | output | 3 | 0 flush, 1 open, 2 write byte, 3 read byte, 4 close |
| cmdOpcode | output | 8 | Instruction for an open command |
| cmdAddrLen | output | 2 | Address bytes in the frame header |
| cmdRead | output | 1 | Frame reads data back |
| cmdAddr | output | ADDR_W | Header address for an open command |
| cmdData | output | 8 | Byte for a write-byte command |
| rspValid | input | 1 | Read response valid |
| rspData | input | 8 | Read response byte (flash status) |

## Verification
The bench aims at page-boundary arithmetic: runs that start mid-page, end mid-page, span several pages, and use the clamped shift values. An off-by-one page end would close frames one byte early or late, and a wrong first-end rule would split an aligned start into an empty first page. Poll termination is tested with status bytes that carry other bits set, and at exactly one read short of the watchdog and exactly at it. A design that tested the whole byte, or counted reads wrongly, would hang, abort early or finish when it should abort. A zero count and a second start during a run confirm that no stray commands appear and that the loaded parameters are not disturbed.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    CK_FLUSH = 3'd0,
    CK_OPEN  = 3'd1,
    CK_WRITE = 3'd2,
    CK_READ  = 3'd3,
    CK_CLOSE = 3'd4
  } cmdKind_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam logic [3:0] MIN_SHIFT = 4'd4;
  localparam logic [3:0] MAX_SHIFT = 4'd12;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic byteSent;
    logic nextPage;
    logic pollClr;
    logic pollInc;
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lastByte;
    logic countZero;
    logic pollLast;
  } dpStatus_t;

  function automatic logic [3:0] clampShift(input logic [3:0] s);
    if (s < MIN_SHIFT) return MIN_SHIFT;
    if (s > MAX_SHIFT) return MAX_SHIFT;
    return s;
  endfunction

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 24,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [3:0]        pageShift,
  output logic [ADDR_W-1:0] curAddr,
  output dpStatus_t         status
);

  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int END_W  = ADDR_W + 1;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  remainQ;
  logic [END_W-1:0]  pageEndQ;
  logic [3:0]        shiftQ;
  logic [POLL_W-1:0] pollQ;

  logic [3:0]       shiftIn;
  logic [END_W-1:0] sizeIn;
  logic [END_W-1:0] firstEnd;
  logic [END_W-1:0] sizeCur;
  logic [END_W-1:0] addrNext;

  always_comb begin
    shiftIn  = clampShift(pageShift);
    sizeIn   = END_W'(1) << shiftIn;
    firstEnd = ({1'b0, startAddr} & ~(sizeIn - END_W'(1))) + sizeIn;
    sizeCur  = END_W'(1) << shiftQ;
    addrNext = {1'b0, addrQ} + END_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      remainQ  <= '0;
      pageEndQ <= '0;
      shiftQ   <= MIN_SHIFT;
    end else if (strobe.load) begin
      addrQ    <= startAddr;
      remainQ  <= byteCount;
      pageEndQ <= firstEnd;
      shiftQ   <= shiftIn;
    end else begin
      if (strobe.byteSent) begin
        addrQ   <= addrQ + ADDR_W'(1);
        remainQ <= remainQ - CNT_W'(1);
      end
      if (strobe.nextPage) begin
        pageEndQ <= pageEndQ + sizeCur;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollQ <= '0;
    end else if (strobe.pollClr) begin
      pollQ <= '0;
    end else if (strobe.pollInc) begin
      pollQ <= pollQ + POLL_W'(1);
    end
  end

  assign curAddr          = addrQ;
  assign status.lastByte  = (remainQ == CNT_W'(1)) || (addrNext == pageEndQ);
  assign status.countZero = (remainQ == '0);
  assign status.pollLast  = (pollQ == POLL_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       countInZero,
  input  dpStatus_t  status,
  input  logic       cmdReady,
  input  logic       inValid,
  input  logic       rspValid,
  input  logic       rspBusy,
  output dpStrobe_t  strobe,
  output logic       cmdValid,
  output cmdKind_e   cmdKind,
  output logic [7:0] cmdOpcode,
  output logic [1:0] cmdAddrLen,
  output logic       cmdRead,
  output logic       inReady,
  output logic       active,
  output logic       done,
  output logic       abortErr
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_FLUSH_WE,
    S_OPEN_WE,
    S_CLOSE_WE,
    S_OPEN_PP,
    S_DATA,
    S_CLOSE_PP,
    S_FLUSH_RS,
    S_OPEN_RS,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_CLOSE_RS
  } state_e;

  state_e stateQ, stateD;
  logic   abortQ;
  logic   doneQ, errQ;
  logic   doneSet, errSet, abortSet;

  always_comb begin
    stateD     = stateQ;
    strobe     = '0;
    cmdValid   = 1'b0;
    cmdKind    = CK_FLUSH;
    cmdOpcode  = 8'h00;
    cmdAddrLen = 2'd0;
    cmdRead    = 1'b0;
    inReady    = 1'b0;
    doneSet    = 1'b0;
    errSet     = 1'b0;
    abortSet   = 1'b0;

    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          if (countInZero) begin
            doneSet = 1'b1;
          end else begin
            strobe.load = 1'b1;
            stateD      = S_FLUSH_WE;
          end
        end
      end
      S_FLUSH_WE: begin
        cmdValid = 1'b1;
        cmdKind  = CK_FLUSH;
        if (cmdReady) stateD = S_OPEN_WE;
      end
      S_OPEN_WE: begin
        cmdValid  = 1'b1;
        cmdKind   = CK_OPEN;
        cmdOpcode = OP_WREN;
        if (cmdReady) stateD = S_CLOSE_WE;
      end
      S_CLOSE_WE: begin
        cmdValid = 1'b1;
        cmdKind  = CK_CLOSE;
        if (cmdReady) stateD = S_OPEN_PP;
      end
      S_OPEN_PP: begin
        cmdValid   = 1'b1;
        cmdKind    = CK_OPEN;
        cmdOpcode  = OP_PROG;
        cmdAddrLen = 2'd3;
        if (cmdReady) stateD = S_DATA;
      end
      S_DATA: begin
        cmdValid = inValid;
        cmdKind  = CK_WRITE;
        inReady  = cmdReady;
        if (inValid && cmdReady) begin
          strobe.byteSent = 1'b1;
          if (status.lastByte) stateD = S_CLOSE_PP;
        end
      end
      S_CLOSE_PP: begin
        cmdValid = 1'b1;
        cmdKind  = CK_CLOSE;
        if (cmdReady) begin
          strobe.nextPage = 1'b1;
          stateD          = S_FLUSH_RS;
        end
      end
      S_FLUSH_RS: begin
        cmdValid = 1'b1;
        cmdKind  = CK_FLUSH;
        if (cmdReady) stateD = S_OPEN_RS;
      end
      S_OPEN_RS: begin
        cmdValid  = 1'b1;
        cmdKind   = CK_OPEN;
        cmdOpcode = OP_RDSR;
        cmdRead   = 1'b1;
        if (cmdReady) begin
          strobe.pollClr = 1'b1;
          stateD         = S_POLL_REQ;
        end
      end
      S_POLL_REQ: begin
        cmdValid = 1'b1;
        cmdKind  = CK_READ;
        if (cmdReady) stateD = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        if (rspValid) begin
          if (rspBusy) begin
            strobe.pollInc = 1'b1;
            if (status.pollLast) begin
              abortSet = 1'b1;
              stateD   = S_CLOSE_RS;
            end else begin
              stateD = S_POLL_REQ;
            end
          end else begin
            stateD = S_CLOSE_RS;
          end
        end
      end
      S_CLOSE_RS: begin
        cmdValid = 1'b1;
        cmdKind  = CK_CLOSE;
        if (cmdReady) begin
          if (abortQ) begin
            errSet = 1'b1;
            stateD = S_IDLE;
          end else if (status.countZero) begin
            doneSet = 1'b1;
            stateD  = S_IDLE;
          end else begin
            stateD = S_FLUSH_WE;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      abortQ <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneSet;
      errQ   <= errSet;
      if (strobe.load)  abortQ <= 1'b0;
      else if (abortSet) abortQ <= 1'b1;
    end
  end

  assign active   = (stateQ != S_IDLE);
  assign done     = doneQ;
  assign abortErr = errQ;

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 24,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [3:0]        pageShift,
  output logic              active,
  output logic              done,
  output logic              abortErr,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [2:0]        cmdKind,
  output logic [7:0]        cmdOpcode,
  output logic [1:0]        cmdAddrLen,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData,
  input  logic              rspValid,
  input  logic [7:0]        rspData
);

  dpStrobe_t strobe;
  dpStatus_t status;
  cmdKind_e  kindE;
  logic      countInZero;

  assign countInZero = (byteCount == '0);

  flash_seq_ctl i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .countInZero(countInZero),
    .status     (status),
    .cmdReady   (cmdReady),
    .inValid    (inValid),
    .rspValid   (rspValid),
    .rspBusy    (rspData[0]),
    .strobe     (strobe),
    .cmdValid   (cmdValid),
    .cmdKind    (kindE),
    .cmdOpcode  (cmdOpcode),
    .cmdAddrLen (cmdAddrLen),
    .cmdRead    (cmdRead),
    .inReady    (inReady),
    .active     (active),
    .done       (done),
    .abortErr   (abortErr)
  );

  flash_seq_dp #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .POLL_LIMIT(POLL_LIMIT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startAddr(startAddr),
    .byteCount(byteCount),
    .pageShift(pageShift),
    .curAddr  (cmdAddr),
    .status   (status)
  );

  assign cmdKind = kindE;
  assign cmdData = inData;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CNT_W-1:0]  byteCount,
  input logic              active,
  input logic              done,
  input logic              abortErr,
  input logic [7:0]        inData,
  input logic              inValid,
  input logic              inReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [2:0]        cmdKind,
  input logic [7:0]        cmdOpcode,
  input logic [1:0]        cmdAddrLen,
  input logic              cmdRead,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [7:0]        cmdData,
  input logic              rspValid,
  input logic [7:0]        rspData
);

  // R1: open headers only in the three legal shapes
  p_open_shape_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == CK_OPEN) |->
      ((cmdOpcode == OP_WREN && cmdAddrLen == 2'd0 && !cmdRead) ||
       (cmdOpcode == OP_PROG && cmdAddrLen == 2'd3 && !cmdRead) ||
       (cmdOpcode == OP_RDSR && cmdAddrLen == 2'd0 && cmdRead)));

  // R2: a stalled command keeps its fields
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady && cmdKind != CK_WRITE) |=>
      (cmdValid && $stable(cmdKind) && $stable(cmdOpcode) &&
       $stable(cmdAddrLen) && $stable(cmdRead) && $stable(cmdAddr)));

  // R4: every accepted stream byte leaves as a write-byte command
  p_stream_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |->
      (cmdValid && cmdReady && cmdKind == CK_WRITE && cmdData == inData));

  // R5: no command is offered while a status response arrives
  p_rsp_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!cmdValid && !$isunknown(rspData)));

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: zero count finishes at once with no command
  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !active && byteCount == '0) |=> (done && !cmdValid && !active));

  // R8: abort and done never coincide
  p_abort_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && abortErr));

  // R10: finishing leaves the engine idle and silent
  p_finish_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done || abortErr) |-> (!active && !cmdValid && !inReady));

endmodule

bind flash_prog_seq flash_seq_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .byteCount (byteCount),
  .active    (active),
  .done      (done),
  .abortErr  (abortErr),
  .inData    (inData),
  .inValid   (inValid),
  .inReady   (inReady),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdKind   (cmdKind),
  .cmdOpcode (cmdOpcode),
  .cmdAddrLen(cmdAddrLen),
  .cmdRead   (cmdRead),
  .cmdAddr   (cmdAddr),
  .cmdData   (cmdData),
  .rspValid  (rspValid),
  .rspData   (rspData)
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;

  localparam int ADDR_W = 24;
  localparam int CNT_W  = 24;
  localparam int WD     = 6;
  localparam int LOG_N  = 2048;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0]  byteCount = '0;
  logic [3:0]        pageShift = 4'd4;
  logic              active, done, abortErr;
  logic [7:0]        inData;
  logic              inValid, inReady;
  logic              cmdValid, cmdReady;
  logic [2:0]        cmdKind;
  logic [7:0]        cmdOpcode;
  logic [1:0]        cmdAddrLen;
  logic              cmdRead;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;
  logic              rspValid = 1'b0;
  logic [7:0]        rspData = 8'h00;

  int checks = 0;
  int errors = 0;

  // controller / flash / source model state
  int          cycCnt = 0;
  int          logCnt = 0;
  logic [45:0] logKey [LOG_N];
  logic [45:0] expKey [LOG_N];
  int          expN = 0;
  int          srcIdx = 0;
  int          srcLimit = 0;
  int          cfgBusy = 0;
  int          busyLeft = 0;
  logic [7:0]  lastOp = 8'h00;

  always #2.5 clk = ~clk;

  flash_prog_seq #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .POLL_LIMIT(WD)
  ) i_flash_prog_seq (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .pageShift(pageShift), .active(active),
    .done(done), .abortErr(abortErr), .inData(inData), .inValid(inValid),
    .inReady(inReady), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdOpcode(cmdOpcode), .cmdAddrLen(cmdAddrLen),
    .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [7:0] byteAt(input int i);
    return 8'(i * 7 + 8'h35);
  endfunction

  function automatic logic [45:0] mkKey(input logic [2:0] k, input logic [7:0] op,
                                        input logic [1:0] al, input logic rd,
                                        input logic [23:0] ad, input logic [7:0] d);
    return {k, (k == 3'd1) ? op : 8'h00, (k == 3'd1) ? al : 2'd0,
            (k == 3'd1) ? rd : 1'b0, (k == 3'd1 && al != 2'd0) ? ad : 24'h0,
            (k == 3'd2) ? d : 8'h00};
  endfunction

  assign cmdReady = (cycCnt % 4) != 3;
  assign inValid  = srcIdx < srcLimit;
  assign inData   = byteAt(srcIdx);

  always @(posedge clk) begin
    cycCnt   <= cycCnt + 1;
    rspValid <= 1'b0;
    if (rstN && cmdValid && cmdReady) begin
      if (logCnt < LOG_N) logKey[logCnt] <= mkKey(cmdKind, cmdOpcode, cmdAddrLen, cmdRead, cmdAddr, cmdData);
      logCnt <= logCnt + 1;
      if (cmdKind == 3'd1) lastOp <= cmdOpcode;
      if (cmdKind == 3'd4 && lastOp == 8'h02) busyLeft <= cfgBusy;
      if (cmdKind == 3'd3) begin
        rspValid <= 1'b1;
        rspData  <= (busyLeft != 0) ? 8'h03 : 8'hFE;
        if (busyLeft != 0) busyLeft <= busyLeft - 1;
      end
    end
    if (rstN && inValid && inReady) srcIdx <= srcIdx + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [7:0] op, input logic [1:0] al,
                      input logic rd, input longint ad, input logic [7:0] d);
    if (expN < LOG_N) expKey[expN] = mkKey(k, op, al, rd, ad[23:0], d);
    expN++;
  endtask

  // one operation: build expected commands, run, compare
  task automatic runOp(input string req, input longint addr, input longint cnt,
                       input int shIn, input int shExp, input int busy,
                       input bit expAbort, input bit poke);
    int base, sbase, cyc, k, mis;
    bit sawDone, sawErr, sawActive;
    longint a, rem, pe, size;
    expN  = 0;
    base  = logCnt;
    sbase = srcIdx;
    size  = 64'd1 << shExp;
    a = addr; rem = cnt; k = 0;
    pe = ((a >> shExp) + 1) << shExp;
    while (rem > 0) begin
      push(3'd0, 0, 0, 0, 0, 0);
      push(3'd1, 8'h06, 2'd0, 1'b0, 0, 0);
      push(3'd4, 0, 0, 0, 0, 0);
      push(3'd1, 8'h02, 2'd3, 1'b0, a, 0);
      do begin
        push(3'd2, 0, 0, 0, 0, byteAt(sbase + k));
        k++; a++; rem--;
      end while (rem > 0 && a != pe);
      push(3'd4, 0, 0, 0, 0, 0);
      pe += size;
      push(3'd0, 0, 0, 0, 0, 0);
      push(3'd1, 8'h05, 2'd0, 1'b1, 0, 0);
      if (busy >= WD) begin
        for (int i = 0; i < WD; i++) push(3'd3, 0, 0, 0, 0, 0);
        push(3'd4, 0, 0, 0, 0, 0);
        break;
      end
      for (int i = 0; i <= busy; i++) push(3'd3, 0, 0, 0, 0, 0);
      push(3'd4, 0, 0, 0, 0, 0);
    end
    @(negedge clk);
    cfgBusy   = busy;
    srcLimit  = srcIdx + int'(cnt);
    startAddr = addr[ADDR_W-1:0];
    byteCount = cnt[CNT_W-1:0];
    pageShift = shIn[3:0];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawDone = done; sawErr = abortErr; sawActive = active; cyc = 0;
    while (!sawDone && !sawErr && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin start = 1'b1; startAddr = '0; byteCount = 5; end
      if (poke && cyc == 21) start = 1'b0;
      if (!sawDone && !sawErr && active) sawActive = 1'b1;
      sawDone = done; sawErr = abortErr;
    end
    check(sawDone == !expAbort && sawErr == expAbort, expAbort ? "R8" : "R6",
          {req, " outcome done/abort"}, {sawDone, sawErr}, {!expAbort, expAbort});
    repeat (8) @(negedge clk);
    check(active == 1'b0, "R10", {req, " idle after finish"}, active, 0);
    if (cnt > 0) check(sawActive, "R10", {req, " active during run"}, sawActive, 1);
    else check(cyc == 0, "R7", {req, " done right after start"}, cyc, 0);
    check(logCnt - base == expN, req, "command count", logCnt - base, expN);
    mis = -1;
    for (int i = 0; i < expN && i < logCnt - base; i++)
      if (mis < 0 && logKey[base + i] != expKey[i]) mis = i;
    if (mis >= 0) check(1'b0, req, $sformatf("command %0d", mis), logKey[base + mis], expKey[mis]);
    else check(1'b1, req, "command sequence", 0, 0);
    check(srcIdx - sbase == int'(cnt), "R4", {req, " bytes taken"}, srcIdx - sbase, cnt);
  endtask

  task automatic t_reset;
    check(!active && !done && !abortErr, "R11", "status after reset",
          {active, done, abortErr}, 0);
    check(!cmdValid && !inReady, "R11", "handshakes after reset", {cmdValid, inReady}, 0);
  endtask

  task automatic t_aligned;   runOp("R1 R2 R6 aligned one page", 24'h000100, 16, 4, 4, 2, 1'b0, 1'b0); endtask
  task automatic t_unaligned; runOp("R3 R4 R10 unaligned multi page", 24'h00003A, 40, 4, 4, 1, 1'b0, 1'b1); endtask
  task automatic t_zero;      runOp("R7 zero count", 24'h000200, 0, 4, 4, 0, 1'b0, 1'b0); endtask
  task automatic t_large;     runOp("R3 R4 page size 256", 24'h0000F0, 300, 8, 8, 0, 1'b0, 1'b0); endtask
  task automatic t_clamp_low; runOp("R9 shift below range", 24'h000005, 20, 2, 4, 0, 1'b0, 1'b0); endtask
  task automatic t_clamp_hi;  runOp("R9 shift above range", 24'h000FFE, 4, 15, 12, 0, 1'b0, 1'b0); endtask
  task automatic t_poll_edge; runOp("R5 R8 busy one short of limit", 24'h000300, 3, 4, 4, WD - 1, 1'b0, 1'b0); endtask
  task automatic t_abort;     runOp("R8 poll watchdog abort", 24'h000400, 3, 4, 4, WD, 1'b1, 1'b0); endtask
  task automatic t_after;     runOp("R6 run after abort", 24'h00041F, 2, 4, 4, 1, 1'b0, 1'b0); endtask

  initial begin
    wait (cycCnt > 150000);
    errors++;
    $display("FAIL watchdog: bench hung, actual %0d cycles expected fewer", cycCnt);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_aligned;
    t_unaligned;
    t_zero;
    t_large;
    t_clamp_low;
    t_clamp_hi;
    t_poll_edge;
    t_abort;
    t_after;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule